// File: doc/BRIEF.md
# Supply Supervisor Event Controller

This block sits between the supply comparators of a power-management domain and the rest of the chip. Seven comparator level inputs cover the main supply, compared against a reset threshold, an alarm threshold and two monitoring bands, and the regulated core supply, compared against over-voltage, under-voltage and reset thresholds. Each input is synchronised and debounced. It is then routed to a sticky interrupt status bit, to a reset request, or to nothing. The route depends on whether the chip is active or in hibernate.

Software sees three registers on a simple write-strobe / combinational-read bus. The interrupt enable register is at address 0. The status register is at address 1, where writing 1 clears a bit. The hibernate option register is at address 2. The interrupt output is level sensitive. A reset request is a pulse of fixed length that starts when a routed reset condition first appears.

Top module: `supply_event_controller`

## Requirements
- R1: A comparator level takes effect only after it has been held for at least DEBOUNCE_CYCLES clocks; a pulse shorter than that causes no status bit and no reset.
- R2: In active mode, a debounced level on cmpLevel[2] sets status bit 0. Level cmpLevel[3] sets bit 1, cmpLevel[4] (core over-voltage) sets bit 2, and cmpLevel[5] (core under-voltage) sets bit 3.
- R3: irq is high exactly when any status bit is set whose enable bit (address 0, bits 4:0) is also set.
- R4: Status bits clear only through a write to address 1, and only where the write data has a 1. Writing 0 leaves a bit unchanged. A bit whose source level is still present sets again.
- R5: In active mode, a rising debounced cmpLevel[0] (main supply below reset level) produces one rstReq pulse exactly RST_PULSE_CYCLES clocks long.
- R6: A rising debounced cmpLevel[6] (core below reset level) produces an rstReq pulse in both active and hibernate mode.
- R7: cmpLevel[1] (main supply alarm) sets status bit 4 only in hibernate with option bit 0 (address 2) set; in active mode it has no effect.
- R8: In hibernate, cmpLevel[0] causes a reset pulse only while option bit 1 is set. Setting that bit while the level is present starts a pulse.
- R9: In hibernate, the band inputs cmpLevel[2] and cmpLevel[3] set status bits 0 and 1 only while option bit 2 is set. The core over-voltage and under-voltage inputs set no status.
- R10: No status bit is set in any cycle in which a reset pulse starts or is running. A level still present sets its bit once the pulse ends.
- R11: Changing the mode input keeps all status bits; only the routing of later events changes.
- R12: After reset, all registers read 0 and irq and rstReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hibernate | input | 1 | 1 = hibernate policy, 0 = active policy |
| cmpLevel | input | 7 | Raw comparator levels; bit map in R2 and R5 to R9 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 enable, 1 status, 2 options) |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, combinational on regAddr |
| irq | output | 1 | Interrupt request level |
| rstReq | output | 1 | Reset request pulse |

## Verification
The hardest case to reach from the ports is a reset and an interrupt source that cross their thresholds in the same debounced cycle, because priority then has to hold back the status bit for the whole pulse. The stimulus raises the core reset and core under-voltage inputs together and samples status while rstReq is high, then again after the pulse ends. The hibernate option gating is also hard to reach. A level is held steady while the option bit is written, so that the reset pulse must start from the register write alone. Random phases mix modes, options, enables and clear masks, with levels held past the debounce window.

// File: rtl/supply_event_pkg.sv
package supply_event_pkg;

  // comparator input positions
  localparam int NUM_CMP       = 7;
  localparam int CMP_MAIN_RST  = 0;
  localparam int CMP_MAIN_ALM  = 1;
  localparam int CMP_BAND_HI   = 2;
  localparam int CMP_BAND_LO   = 3;
  localparam int CMP_CORE_OV   = 4;
  localparam int CMP_CORE_UV   = 5;
  localparam int CMP_CORE_RST  = 6;

  // status bit positions
  localparam int NUM_STAT      = 5;
  localparam int ST_BAND_HI    = 0;
  localparam int ST_BAND_LO    = 1;
  localparam int ST_CORE_OV    = 2;
  localparam int ST_CORE_UV    = 3;
  localparam int ST_ALARM      = 4;

  // hibernate option bit positions
  localparam int NUM_OPT       = 3;
  localparam int OPT_ALARM     = 0;
  localparam int OPT_HIB_RST   = 1;
  localparam int OPT_HIB_BAND  = 2;

  localparam int ADDR_W        = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_IEN  = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_OPT  = 2'd2,
    ADDR_RSV  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic [NUM_STAT-1:0] statusSet;
    logic                rstFire;
  } ctrlStrobe_t;

endpackage

// File: rtl/supply_event_filter.sv
module supply_event_filter #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic levelOut
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);

  logic syncA;
  logic syncB;
  logic [CNT_W-1:0] stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= 1'b0;
      syncB     <= 1'b0;
      stableCnt <= '0;
      levelOut  <= 1'b0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (syncB == levelOut) begin
        stableCnt <= '0;
      end else if (stableCnt == CNT_W'(DEB_CYCLES - 1)) begin
        levelOut  <= syncB;
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/supply_event_ctrl.sv
module supply_event_ctrl
  import supply_event_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hibernate,
  input  logic [NUM_CMP-1:0] levels,
  input  logic [NUM_OPT-1:0] opts,
  input  logic               rstActive,
  output ctrlStrobe_t        strobe
);
  logic [NUM_STAT-1:0] routeInt;
  logic                rstCause;
  logic                rstCauseQ;
  logic                bandAllowed;

  always_comb begin
    bandAllowed = !hibernate || opts[OPT_HIB_BAND];
    routeInt = '0;
    routeInt[ST_BAND_HI] = levels[CMP_BAND_HI] && bandAllowed;
    routeInt[ST_BAND_LO] = levels[CMP_BAND_LO] && bandAllowed;
    routeInt[ST_CORE_OV] = levels[CMP_CORE_OV] && !hibernate;
    routeInt[ST_CORE_UV] = levels[CMP_CORE_UV] && !hibernate;
    routeInt[ST_ALARM]   = levels[CMP_MAIN_ALM] && hibernate && opts[OPT_ALARM];

    rstCause = levels[CMP_CORE_RST] ||
               (levels[CMP_MAIN_RST] && (!hibernate || opts[OPT_HIB_RST]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstCauseQ <= 1'b0;
    else       rstCauseQ <= rstCause;
  end

  always_comb begin
    strobe.rstFire   = rstCause && !rstCauseQ;
    strobe.statusSet = (strobe.rstFire || rstActive) ? '0 : routeInt;
  end
endmodule

// File: rtl/supply_event_datapath.sv
module supply_event_datapath
  import supply_event_pkg::*;
#(
  parameter int DEB_CYCLES = 16,
  parameter int RST_LEN    = 32,
  parameter int DATA_W     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CMP-1:0]  cmpRaw,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  ctrlStrobe_t         strobe,
  output logic [NUM_CMP-1:0]  levels,
  output logic [NUM_STAT-1:0] status,
  output logic [NUM_STAT-1:0] ien,
  output logic [NUM_OPT-1:0]  opts,
  output logic                rstActive,
  output logic                irq
);
  localparam int PULSE_W = $clog2(RST_LEN + 1);

  logic [PULSE_W-1:0]  pulseCnt;
  logic [NUM_STAT-1:0] clearMask;
  logic                wrIen;
  logic                wrStat;
  logic                wrOpt;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_filt
    supply_event_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (cmpRaw[g]),
      .levelOut (levels[g])
    );
  end

  always_comb begin
    wrIen     = regWrEn && (regAddr_e'(regAddr) == ADDR_IEN);
    wrStat    = regWrEn && (regAddr_e'(regAddr) == ADDR_STAT);
    wrOpt     = regWrEn && (regAddr_e'(regAddr) == ADDR_OPT);
    clearMask = wrStat ? regWrData[NUM_STAT-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ien    <= '0;
      opts   <= '0;
      status <= '0;
    end else begin
      if (wrIen) ien  <= regWrData[NUM_STAT-1:0];
      if (wrOpt) opts <= regWrData[NUM_OPT-1:0];
      status <= (status & ~clearMask) | strobe.statusSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.rstFire) begin
      pulseCnt <= PULSE_W'(RST_LEN);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign rstActive = (pulseCnt != '0);
  assign irq       = |(status & ien);

  always_comb begin
    regRdData = '0;
    case (regAddr_e'(regAddr))
      ADDR_IEN:  regRdData[NUM_STAT-1:0] = ien;
      ADDR_STAT: regRdData[NUM_STAT-1:0] = status;
      ADDR_OPT:  regRdData[NUM_OPT-1:0]  = opts;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/supply_event_controller.sv
module supply_event_controller
  import supply_event_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES  = 16,
  parameter int RST_PULSE_CYCLES = 32,
  parameter int DATA_W           = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hibernate,
  input  logic [NUM_CMP-1:0] cmpLevel,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irq,
  output logic               rstReq
);
  ctrlStrobe_t         strobe;
  logic [NUM_CMP-1:0]  levels;
  logic [NUM_STAT-1:0] statusVec;
  logic [NUM_STAT-1:0] ienVec;
  logic [NUM_OPT-1:0]  optVec;
  logic                rstActive;

  supply_event_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hibernate (hibernate),
    .levels    (levels),
    .opts      (optVec),
    .rstActive (rstActive),
    .strobe    (strobe)
  );

  supply_event_datapath #(
    .DEB_CYCLES (DEBOUNCE_CYCLES),
    .RST_LEN    (RST_PULSE_CYCLES),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmpRaw    (cmpLevel),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (strobe),
    .levels    (levels),
    .status    (statusVec),
    .ien       (ienVec),
    .opts      (optVec),
    .rstActive (rstActive),
    .irq       (irq)
  );

  assign rstReq = rstActive;
endmodule

// File: rtl/supply_event_checker.sv
module supply_event_checker
  import supply_event_pkg::*;
#(
  parameter int RST_LEN = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                hibernate,
  input logic                regWrEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [NUM_STAT-1:0] statusVec,
  input logic [NUM_STAT-1:0] ienVec,
  input logic [NUM_OPT-1:0]  optVec,
  input logic                irq,
  input logic                rstReq
);
  logic [31:0] highCnt;
  logic        wrStat;

  assign wrStat = regWrEn && (regAddr == 2'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       highCnt <= '0;
    else if (rstReq) highCnt <= highCnt + 1;
    else             highCnt <= '0;
  end

  // R5: a finished pulse lasted at least the configured length
  a_r5_pulse_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstReq) |-> (highCnt >= RST_LEN));

  // R10: no new status bit while a reset pulse was running
  a_r10_reset_priority: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstReq) |-> ((statusVec & ~$past(statusVec)) == '0));

  // R4 / R11: bits only drop after a status write, whatever the mode does
  a_r4_clear_by_write_only: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrStat) |-> (($past(statusVec) & ~statusVec) == '0));

  // R9: no core over/under-voltage status raised under hibernate routing
  a_r9_core_quiet_in_hib: assert property (@(posedge clk) disable iff (!rstN)
    $past(hibernate) |-> ((statusVec[ST_CORE_UV:ST_CORE_OV] &
                           ~$past(statusVec[ST_CORE_UV:ST_CORE_OV])) == '0));

  // R7: alarm needs hibernate and its option
  a_r7_alarm_gated: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!hibernate) || $past(!optVec[OPT_ALARM])) |->
      !(statusVec[ST_ALARM] && !$past(statusVec[ST_ALARM])));

  // R3: with every enable off the interrupt stays low
  a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (ienVec == '0) |-> !irq);
endmodule

bind supply_event_controller supply_event_checker #(.RST_LEN(RST_PULSE_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hibernate (hibernate),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .statusVec (statusVec),
  .ienVec    (ienVec),
  .optVec    (optVec),
  .irq       (irq),
  .rstReq    (rstReq)
);

// File: tb/test_supply_event_controller.sv
module test_supply_event_controller;
  localparam int DEB    = 4;
  localparam int RSTLEN = 8;
  localparam int DW     = 8;
  localparam int SETTLE = DEB + 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hibernate = 1'b0;
  logic [6:0]    cmpLevel = '0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic          irq;
  logic          rstReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  supply_event_controller #(
    .DEBOUNCE_CYCLES  (DEB),
    .RST_PULSE_CYCLES (RSTLEN),
    .DATA_W           (DW)
  ) i_supply_event_controller (
    .clk(clk), .rstN(rstN), .hibernate(hibernate), .cmpLevel(cmpLevel),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq), .rstReq(rstReq)
  );

  function automatic logic [4:0] expSet(logic [6:0] c, logic hib, logic [2:0] o);
    logic [4:0] s;
    logic band;
    band = !hib || o[2];
    s[0] = c[2] && band;
    s[1] = c[3] && band;
    s[2] = c[4] && !hib;
    s[3] = c[5] && !hib;
    s[4] = c[1] && hib && o[0];
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [DW-1:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic countPulse(int win, output int hi);
    hi = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (rstReq) hi++;
    end
  endtask

  task automatic clearAll();
    cmpLevel = '0;
    cyc(SETTLE);
    regWrite(2'd1, 8'h1f);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    logic [4:0] model;
    logic [4:0] ienM;
    logic [2:0] optM;
    logic [6:0] cmpM;
    logic hibM;
    int hi;
    void'($urandom(32'h5a17));

    cyc(3);
    // R12 reset state
    regRead(2'd0, rd); check("R12 ien", rd, 0);
    regRead(2'd1, rd); check("R12 status", rd, 0);
    regRead(2'd2, rd); check("R12 opts", rd, 0);
    check("R12 irq", irq, 0);
    check("R12 rstReq", rstReq, 0);
    @(negedge clk); rstN = 1'b1;
    cyc(2);

    // R1 short glitch filtered
    cmpLevel[2] = 1'b1; cyc(DEB - 1); cmpLevel[2] = 1'b0;
    cyc(SETTLE);
    regRead(2'd1, rd); check("R1 glitch", rd, 0);
    cmpLevel[0] = 1'b1; cyc(DEB - 1); cmpLevel[0] = 1'b0;
    countPulse(SETTLE + RSTLEN, hi); check("R1 reset glitch", hi, 0);

    // R2 band high sets bit 0 after debounce
    cmpLevel[2] = 1'b1; cyc(SETTLE);
    regRead(2'd1, rd); check("R2 band hi", rd, 8'h01);
    // R3 irq needs enable
    check("R3 irq masked", irq, 0);
    regWrite(2'd0, 8'h01); #1;
    check("R3 irq enabled", irq, 1);
    // R4 w1c while level still present: sets again
    regWrite(2'd1, 8'h01); regRead(2'd1, rd);
    check("R4 reassert", rd, 8'h01);
    cmpLevel[2] = 1'b0; cyc(SETTLE);
    regWrite(2'd1, 8'h01); regRead(2'd1, rd);
    check("R4 cleared", rd, 0);
    check("R3 irq low", irq, 0);
    // R2 other sources; R4 writing 0 keeps
    cmpLevel[5:3] = 3'b111; cyc(SETTLE);
    regRead(2'd1, rd); check("R2 lo/ov/uv", rd, 8'h0e);
    cmpLevel[5:3] = 3'b000; cyc(SETTLE);
    regWrite(2'd1, 8'h00); regRead(2'd1, rd);
    check("R4 write zero keeps", rd, 8'h0e);
    regWrite(2'd1, 8'h04); regRead(2'd1, rd);
    check("R4 partial clear", rd, 8'h0a);
    clearAll();

    // R5 active main reset pulse
    cmpLevel[0] = 1'b1;
    countPulse(SETTLE + RSTLEN + 8, hi); check("R5 pulse length", hi, RSTLEN);
    countPulse(20, hi); check("R5 single pulse", hi, 0);
    cmpLevel[0] = 1'b0; cyc(SETTLE);

    // R7 alarm ignored in active, gated in hibernate
    cmpLevel[1] = 1'b1; cyc(SETTLE);
    regRead(2'd1, rd); check("R7 active ignore", rd, 0);
    hibernate = 1'b1; cyc(4);
    regRead(2'd1, rd); check("R7 hib no opt", rd, 0);
    regWrite(2'd2, 8'h01); cyc(1);
    regRead(2'd1, rd); check("R7 hib opt", rd, 8'h10);
    cmpLevel[1] = 1'b0; cyc(SETTLE);
    regWrite(2'd1, 8'h1f); regWrite(2'd2, 8'h00);

    // R9 hibernate bands gated, core OV/UV dropped
    cmpLevel[5:2] = 4'hf; cyc(SETTLE);
    regRead(2'd1, rd); check("R9 no opt", rd, 0);
    regWrite(2'd2, 8'h04); cyc(1);
    regRead(2'd1, rd); check("R9 band opt", rd, 8'h03);
    cmpLevel[5:2] = 4'h0; cyc(SETTLE);
    regWrite(2'd1, 8'h1f); regWrite(2'd2, 8'h00);

    // R8 hibernate main reset gated by option
    cmpLevel[0] = 1'b1;
    countPulse(SETTLE + RSTLEN, hi); check("R8 no opt", hi, 0);
    regWrite(2'd2, 8'h02);
    countPulse(RSTLEN + 6, hi); check("R8 opt starts pulse", hi, RSTLEN);
    cmpLevel[0] = 1'b0; cyc(SETTLE);
    regWrite(2'd2, 8'h00);

    // R6 core reset in hibernate
    cmpLevel[6] = 1'b1;
    countPulse(SETTLE + RSTLEN + 6, hi); check("R6 hib pulse", hi, RSTLEN);
    cmpLevel[6] = 1'b0; cyc(SETTLE);

    // R11 mode change keeps status
    hibernate = 1'b0;
    cmpLevel[4] = 1'b1; cyc(SETTLE);
    cmpLevel[4] = 1'b0; cyc(SETTLE);
    hibernate = 1'b1; cyc(3);
    regRead(2'd1, rd); check("R11 to hib", rd, 8'h04);
    hibernate = 1'b0; cyc(3);
    regRead(2'd1, rd); check("R11 to active", rd, 8'h04);
    clearAll();

    // R10 reset wins over simultaneous under-voltage
    cmpLevel[6] = 1'b1; cmpLevel[5] = 1'b1;
    while (!rstReq) @(negedge clk);
    regRead(2'd1, rd); check("R10 held off start", rd, 0);
    cyc(RSTLEN - 2);
    regRead(2'd1, rd); check("R10 held off end", rd, 0);
    cyc(4);
    regRead(2'd1, rd); check("R10 after pulse", rd, 8'h08);
    cmpLevel[6] = 1'b0;
    clearAll();

    // random phase (R2 R3 R4 R7 R9 R11)
    model = '0; optM = '0; hibM = 1'b0; cmpM = '0;
    for (int it = 0; it < 60; it++) begin
      optM = 3'($urandom);
      regWrite(2'd2, {5'd0, optM});
      model |= expSet(cmpM, hibM, optM);
      hibM = 1'($urandom);
      hibernate = hibM;
      model |= expSet(cmpM, hibM, optM);
      cmpM = {1'b0, 5'($urandom), 1'b0};
      cmpLevel = cmpM;
      cyc(SETTLE);
      model |= expSet(cmpM, hibM, optM);
      ienM = 5'($urandom);
      regWrite(2'd0, {3'd0, ienM});
      begin
        logic [4:0] m;
        m = 5'($urandom);
        regWrite(2'd1, {3'd0, m});
        model = (model & ~m) | expSet(cmpM, hibM, optM);
      end
      regRead(2'd1, rd); check("R4 random status", rd, {3'd0, model});
      check("R3 random irq", irq, |(model & ienM));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule